// File: doc/BRIEF.md
# Contact Bounce Filter

This block cleans up a single mechanical contact or other noisy Boolean signal before other logic sees it. The raw level first passes through a two-flop synchroniser. Two on-delay timers then watch the synchronised level. One runs while the level is high and the other runs while it is low. Each timer advances only on clock cycles where the millisecond tick enable is high. A timer reaches its preset when it has counted `db_time_i` ticks without a break.

When the high-side timer reaches its preset, it sets a bistable. When the low-side timer reaches its preset, it clears the bistable. The bistable drives the filtered output. A level change therefore reaches the output only after the new level has held for the programmed number of ticks. Any pulse shorter than that is dropped.

The debounce time is a live input, not a constant. A single instance can therefore be retuned at run time. Setting the debounce time to zero turns the filter into a plain synchroniser with one extra register stage.

Top module: `input_debouncer`

## Requirements
- R1: While `rst_ni` is low, `filt_o` is 0 and both elapsed counts are 0. After reset is released with `raw_i` low, `filt_o` stays 0.
- R2: `filt_o` is low, `raw_i` rises, and `tick_i` is held at 1 with `db_time_i = N`. Then `filt_o` goes to 1 at the (N+3)th rising clock edge after the change and not before. This counts two synchroniser stages, N counting edges and one output register.
- R3: `filt_o` is high, `raw_i` falls, and `tick_i` is held at 1 with `db_time_i = N`. Then `filt_o` goes to 0 at the (N+3)th rising clock edge after the change.
- R4: A pulse on `raw_i` whose synchronised length is shorter than `db_time_i` ticks leaves `filt_o` unchanged.
- R5: A break in the new level restarts its timer from zero. This holds even if the break is only one cycle long. A full `db_time_i` ticks of unbroken level are needed after the break.
- R6: Time advances only on cycles with `tick_i = 1`. When `db_time_i > 0` and `tick_i` stays 0, `filt_o` does not change, however long `raw_i` holds a new level.
- R7: When `db_time_i = 0`, `filt_o` copies `raw_i` three clock edges later, whatever the value of `tick_i`.
- R8: Each elapsed count stops at `db_time_i` and does not wrap. `filt_o` stays constant while `raw_i` holds its level for far more than 2^`TW` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base enable, nominally once per millisecond |
| raw_i | input | 1 | Unfiltered input level |
| db_time_i | input | TW | Debounce time in ticks |
| filt_o | output | 1 | Debounced level |

## Verification
The bench builds the filter with `TW = 4`, so the debounce time spans 0 to 15 ticks. At that width, holds of 60 ticks and more run well past the count range. This brings the no-wrap behaviour within reach in a few hundred cycles. The narrow width also lets random runs that redraw the debounce time hit the zero setting and the maximum setting often. The tick enable runs both sparse and continuous during those runs, so bounces that end just short of the threshold and just past it both occur many times.

// File: rtl/deb_pkg.sv
package deb_pkg;
  parameter int unsigned DEB_TW_DEF   = 8;
  parameter int unsigned DEB_SYNC_DEF = 2;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;
endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
  parameter int unsigned STAGES = deb_pkg::DEB_SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/deb_ondelay.sv
module deb_ondelay #(
  parameter int unsigned TW = deb_pkg::DEB_TW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] pt_i,
  output logic          done_o,
  output logic [TW-1:0] et_o
);
  logic [TW-1:0] et_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    et_q <= '0;
    else if (!run_i)                et_q <= '0;
    else if (tick_i && et_q < pt_i) et_q <= et_q + 1'b1;  // saturates at preset
  end

  assign done_o = run_i && (et_q >= pt_i);
  assign et_o   = et_q;
endmodule

// File: rtl/deb_latch.sv
module deb_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/input_debouncer.sv
module input_debouncer #(
  parameter int unsigned TW          = deb_pkg::DEB_TW_DEF,
  parameter int unsigned SYNC_STAGES = deb_pkg::DEB_SYNC_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          raw_i,
  input  logic [TW-1:0] db_time_i,
  output logic          filt_o
);
  import deb_pkg::*;

  localparam int unsigned NPOL = 2;

  logic                     sync_lvl;
  logic [NPOL-1:0]          done_w;
  logic [NPOL-1:0][TW-1:0]  et_w;

  deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (sync_lvl)
  );

  for (genvar g = 0; g < NPOL; g++) begin : g_tmr
    localparam pol_e POL = pol_e'(g);
    logic run;
    assign run = (POL == POL_HIGH) ? sync_lvl : !sync_lvl;

    deb_ondelay #(.TW(TW)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .tick_i (tick_i),
      .pt_i   (db_time_i),
      .done_o (done_w[g]),
      .et_o   (et_w[g])
    );
  end

  deb_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done_w[POL_HIGH]),
    .clr_i  (done_w[POL_LOW]),
    .q_o    (filt_o)
  );
endmodule

// File: rtl/deb_chk.sv
module deb_chk #(
  parameter int unsigned TW = deb_pkg::DEB_TW_DEF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic [TW-1:0] db_time_i,
  input logic          filt_o,
  input logic          sync_lvl,
  input logic [TW-1:0] et_hi,
  input logic [TW-1:0] et_lo
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (filt_o == 1'b0 && et_hi == '0 && et_lo == '0); // R1
    end
  end

  AST_CHANGE_FOLLOWS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> filt_o == $past(sync_lvl)); // R2

  AST_ONE_TIMER_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(et_hi != '0 && et_lo != '0)); // R5

  AST_NO_TICK_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && sync_lvl) |=> $stable(et_hi)); // R6

  AST_ZERO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_time_i == '0) |=> filt_o == $past(sync_lvl)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl && $past(sync_lvl)) |-> et_hi >= $past(et_hi)); // R8
endmodule

bind input_debouncer deb_chk #(.TW(TW)) u_deb_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .db_time_i (db_time_i),
  .filt_o    (filt_o),
  .sync_lvl  (sync_lvl),
  .et_hi     (et_w[1]),
  .et_lo     (et_w[0])
);

// File: tb/test_input_debouncer.sv
module test_input_debouncer;
  localparam int CLK_PERIOD = 10;
  localparam int TW         = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick = 1'b0;
  logic          raw = 1'b0;
  logic [TW-1:0] db = '0;
  logic          filt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference: one stability counter per run of the synchronised level
  bit m_s1 = 1'b0, m_s2 = 1'b0, m_run = 1'b0, m_out = 1'b0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  input_debouncer #(.TW(TW)) i_input_debouncer (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .raw_i     (raw),
    .db_time_i (db),
    .filt_o    (filt)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: filt_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int cur;
    bit nxt;
    cur = (m_s2 == m_run) ? m_cnt : 0;
    nxt = (cur >= int'(db)) ? m_s2 : m_out;
    if (tick && cur < int'(db)) cur++;
    m_cnt = cur;
    m_run = m_s2;
    m_out = nxt;
    m_s2  = m_s1;
    m_s1  = raw;
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, filt, m_out);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    check("R1 reset", filt, 1'b0);
    rst_ni = 1'b1;
    db = 4'd3; tick = 1'b1;
    run(5, "R1");
    check("R1 idle", filt, 1'b0);

    // R7: zero debounce time, tick ignored
    db = 4'd0; tick = 1'b0; raw = 1'b1;
    run(2, "R7"); check("R7 rise early", filt, 1'b0);
    run(1, "R7"); check("R7 rise", filt, 1'b1);
    raw = 1'b0;
    run(2, "R7"); check("R7 fall early", filt, 1'b1);
    run(1, "R7"); check("R7 fall", filt, 1'b0);
    run(4, "R7");

    // R2 / R3: exact N+3 latency with continuous ticks
    db = 4'd5; tick = 1'b1; raw = 1'b1;
    run(7, "R2"); check("R2 early", filt, 1'b0);
    run(1, "R2"); check("R2 edge", filt, 1'b1);
    raw = 1'b0;
    run(7, "R3"); check("R3 early", filt, 1'b1);
    run(1, "R3"); check("R3 edge", filt, 1'b0);

    // R4: short pulse dropped
    db = 4'd6; raw = 1'b1;
    run(3, "R4");
    raw = 1'b0;
    run(20, "R4"); check("R4 pulse", filt, 1'b0);

    // R5: one-cycle dip restarts the count
    db = 4'd4; raw = 1'b1;
    run(3, "R5");
    raw = 1'b0;
    run(1, "R5");
    raw = 1'b1;
    run(3, "R5"); check("R5 no early rise", filt, 1'b0);
    run(3, "R5"); check("R5 restart", filt, 1'b0);
    run(1, "R5"); check("R5 rise", filt, 1'b1);
    raw = 1'b0;
    run(12, "R5");

    // R6: no tick, no progress
    db = 4'd3; tick = 1'b0; raw = 1'b1;
    run(40, "R6"); check("R6 held low", filt, 1'b0);
    tick = 1'b1;
    run(6, "R6"); check("R6 ticks resume", filt, 1'b1);
    tick = 1'b0; raw = 1'b0;
    run(40, "R6"); check("R6 held high", filt, 1'b1);

    // R8: long holds at maximum preset
    db = 4'd15; tick = 1'b1; raw = 1'b1;
    run(60, "R8"); check("R8 long high", filt, 1'b1);
    raw = 1'b0;
    run(17, "R8"); check("R8 fall early", filt, 1'b1);
    run(1, "R8"); check("R8 fall", filt, 1'b0);
    run(60, "R8"); check("R8 long low", filt, 1'b0);

    // random bounce with mixed tick density and retuned debounce time
    for (int blk = 0; blk < 60; blk++) begin
      db = TW'($urandom % 16);
      if (blk % 4 == 0) db = '0;
      for (int i = 0; i < 50; i++) begin
        tick = (blk % 2 == 0) ? 1'b1 : ($urandom % 3 == 0);
        if ($urandom % (2 + blk % 12) == 0) raw = ~raw;
        cycle("R2 R3 R4 random");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule